// File: doc/BRIEF.md
# PRBS Bit Error Rate Tester

This block tests a single serial link bit by bit. Its transmit side sends a maximal-length pseudo-random bit sequence. Its receive side watches the returning stream and waits for the all-ones seed window. It then locks onto the sequence and counts every bit that disagrees with a locally generated reference. One bit is sent and one bit is taken in on each clock-enable strobe. A design that embeds the tester drives the strobe at the line bit rate and loops the transmit bit, through the path under test, back to the receive bit.

Five level inputs drive the block: a polynomial-length select and four controls that act only on their low-to-high transition. These four are generator reseed, transmitter start, receiver start and error-count clear. The block reports a lock flag and a saturating 16-bit error count.

Top module: `prbs_ber_tester`

## Requirements
- R1: After reset the lock flag is 0, the error count is 0 and the transmit bit is 0.
- R2: A rising edge on `txStart` enables transmission from the next cycle. While `txStart` is low the transmit bit is 0 and the generator holds its state. After a restart the sequence resumes where it stopped.
- R3: With `longMode` = 1 the sequence obeys x^23+x^18+1, so bit k = bit(k-23) XOR bit(k-18). With `longMode` = 0 it obeys x^15+x^14+1, so bit k = bit(k-15) XOR bit(k-14). After a reseed the first 23 or 15 bits sent are all ones.
- R4: A rising edge on `genReset` reloads the generator with the all-ones seed of the selected length.
- R5: A rising edge on `rxStart` clears the lock flag and starts a seed search. The lock flag rises on the strobe that completes 23 (long) or 15 (short) consecutive received ones.
- R6: After lock, each strobed received bit that differs from the reference sequence adds one to the error count. Matching bits leave it unchanged.
- R7: While `rxStart` is low, received bits are not compared. The error count and the lock flag hold.
- R8: A rising edge on `errClear` sets the error count to 0. This wins over an error on the same strobe.
- R9: The error count stops at 65535 and does not wrap.
- R10: Without a strobe on `bitEn`, received and transmitted bits have no effect on the count or on the generator.
- R11: The controls act on edges only. Holding `genReset` or `errClear` high after the rise neither reseeds the generator again nor keeps the count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | Bit strobe: one transmit and one receive bit per high cycle |
| longMode | input | 1 | 1 selects the 23-stage polynomial, 0 the 15-stage one |
| genReset | input | 1 | Rising edge reseeds the generator |
| txStart | input | 1 | Rising edge starts transmission, low stops it |
| rxStart | input | 1 | Rising edge arms the receiver, low freezes comparison |
| errClear | input | 1 | Rising edge zeroes the error count |
| rxBit | input | 1 | Received serial bit |
| txBit | output | 1 | Transmitted serial bit |
| lockFlag | output | 1 | Receiver has found the seed and is comparing |
| errCount | output | 16 | Saturating count of mismatched bits |

## Verification
The embedded properties check the counter rules on every cycle. The count holds without a strobe or while the receiver is off. It moves by at most one per cycle, stays at its maximum, and is zero after a clear. The lock flag falls after arming and rises only on a strobe while the receiver is running. Only the bench scenarios can show that the transmitted bits follow the chosen recurrence and that lock comes after exactly 15 or 23 ones. They also show that held controls do not retrigger and that the error total matches the number of injected flips.

// File: rtl/prbs_ber_pkg.sv
package prbs_ber_pkg;
  localparam int LONG_LEN  = 23;
  localparam int LONG_TAP  = 18;
  localparam int SHORT_LEN = 15;
  localparam int SHORT_TAP = 14;
  localparam int REG_W     = LONG_LEN;

  typedef logic [REG_W-1:0] lfsrState_t;

  typedef struct packed {
    logic seedLoad;
    logic txOn;
    logic rxArm;
    logic rxOn;
    logic cntClear;
  } berCtrl_t;

  function automatic lfsrState_t lfsrMask(input logic longMode);
    return longMode ? {REG_W{1'b1}}
                    : {{(REG_W-SHORT_LEN){1'b0}}, {SHORT_LEN{1'b1}}};
  endfunction

  function automatic logic lfsrFeedback(input lfsrState_t s, input logic longMode);
    return longMode ? (s[LONG_LEN-1] ^ s[LONG_TAP-1])
                    : (s[SHORT_LEN-1] ^ s[SHORT_TAP-1]);
  endfunction

  function automatic logic lfsrHead(input lfsrState_t s, input logic longMode);
    return longMode ? s[LONG_LEN-1] : s[SHORT_LEN-1];
  endfunction

  function automatic lfsrState_t lfsrStep(input lfsrState_t s, input logic longMode);
    return {s[REG_W-2:0], lfsrFeedback(s, longMode)} & lfsrMask(longMode);
  endfunction
endpackage

// File: rtl/prbs_ber_ctrl.sv
module prbs_ber_ctrl
  import prbs_ber_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     genResetIn,
  input  logic     txStartIn,
  input  logic     rxStartIn,
  input  logic     errClearIn,
  output berCtrl_t strobes
);
  localparam int NUM_CTRL = 4;

  logic [NUM_CTRL-1:0] nowV, prevV, riseV;
  logic txOnQ, rxOnQ;

  assign nowV  = {errClearIn, rxStartIn, txStartIn, genResetIn};
  assign riseV = nowV & ~prevV;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevV <= '0;
      txOnQ <= 1'b0;
      rxOnQ <= 1'b0;
    end else begin
      prevV <= nowV;
      if (riseV[1])        txOnQ <= 1'b1;
      else if (!txStartIn) txOnQ <= 1'b0;
      if (riseV[2])        rxOnQ <= 1'b1;
      else if (!rxStartIn) rxOnQ <= 1'b0;
    end
  end

  always_comb begin
    strobes.seedLoad = riseV[0];
    strobes.txOn     = txOnQ;
    strobes.rxArm    = riseV[2];
    strobes.rxOn     = rxOnQ;
    strobes.cntClear = riseV[3];
  end

  // R2
  tx_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txStartIn |=> !txOnQ);

  // R5
  rx_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rxArm && rxStartIn) |=> rxOnQ);
endmodule

// File: rtl/prbs_ber_dp.sv
module prbs_ber_dp
  import prbs_ber_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitEn,
  input  logic             longMode,
  input  logic             rxBit,
  input  berCtrl_t         ctrl,
  output logic             txBit,
  output logic             lockFlag,
  output logic [CNT_W-1:0] errCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  lfsrState_t genState, windowQ, refState, newWindow, seedPat;
  logic lockQ, expectBit, mismatch, seedHit;
  logic [CNT_W-1:0] cntQ;

  assign seedPat = lfsrMask(longMode);

  // transmit generator
  always_ff @(posedge clk) begin
    if (!rstN)                    genState <= {REG_W{1'b1}};
    else if (ctrl.seedLoad)       genState <= seedPat;
    else if (ctrl.txOn && bitEn)  genState <= lfsrStep(genState, longMode);
  end

  assign txBit = ctrl.txOn & lfsrHead(genState, longMode);

  // receive: seed search, then free-running reference
  assign newWindow = {windowQ[REG_W-2:0], rxBit} & seedPat;
  assign seedHit   = (newWindow == seedPat);
  assign expectBit = lfsrFeedback(refState, longMode);
  assign mismatch  = ctrl.rxOn && bitEn && lockQ && !ctrl.rxArm && (rxBit != expectBit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockQ    <= 1'b0;
      windowQ  <= '0;
      refState <= {REG_W{1'b1}};
    end else if (ctrl.rxArm) begin
      lockQ   <= 1'b0;
      windowQ <= '0;
    end else if (ctrl.rxOn && bitEn) begin
      if (!lockQ) begin
        windowQ <= newWindow;
        if (seedHit) begin
          lockQ    <= 1'b1;
          refState <= seedPat;
        end
      end else begin
        refState <= lfsrStep(refState, longMode);
      end
    end
  end

  // saturating error counter
  always_ff @(posedge clk) begin
    if (!rstN)                            cntQ <= '0;
    else if (ctrl.cntClear)               cntQ <= '0;
    else if (mismatch && cntQ != CNT_MAX) cntQ <= cntQ + CNT_W'(1);
  end

  assign lockFlag = lockQ;
  assign errCount = cntQ;

  // R9
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntQ == CNT_MAX && !ctrl.cntClear) |=> cntQ == CNT_MAX);

  // R7
  count_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.rxOn && !ctrl.cntClear) |=> $stable(cntQ));

  // R10
  idle_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!bitEn && !ctrl.cntClear) |=> $stable(cntQ));

  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.cntClear |=> cntQ == '0);

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.cntClear |=> (cntQ == $past(cntQ)) || (cntQ == $past(cntQ) + CNT_W'(1)));

  // R5
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockQ) |-> $past(ctrl.rxOn && bitEn));

  // R5
  arm_unlock_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.rxArm |=> !lockQ);
endmodule

// File: rtl/prbs_ber_tester.sv
module prbs_ber_tester
  import prbs_ber_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitEn,
  input  logic             longMode,
  input  logic             genReset,
  input  logic             txStart,
  input  logic             rxStart,
  input  logic             errClear,
  input  logic             rxBit,
  output logic             txBit,
  output logic             lockFlag,
  output logic [CNT_W-1:0] errCount
);
  berCtrl_t ctrlStrobes;

  prbs_ber_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .genResetIn (genReset),
    .txStartIn  (txStart),
    .rxStartIn  (rxStart),
    .errClearIn (errClear),
    .strobes    (ctrlStrobes)
  );

  prbs_ber_dp #(.CNT_W(CNT_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .bitEn    (bitEn),
    .longMode (longMode),
    .rxBit    (rxBit),
    .ctrl     (ctrlStrobes),
    .txBit    (txBit),
    .lockFlag (lockFlag),
    .errCount (errCount)
  );
endmodule

// File: tb/tb_prbs_ber_tester.sv
module tb_prbs_ber_tester;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, bitEn, longMode, genReset, txStart, rxStart, errClear, flip;
  logic rxBit, txBit, lockFlag;
  logic [15:0] errCount;

  assign rxBit = txBit ^ flip;

  prbs_ber_tester dut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .longMode(longMode),
    .genReset(genReset), .txStart(txStart), .rxStart(rxStart),
    .errClear(errClear), .rxBit(rxBit), .txBit(txBit),
    .lockFlag(lockFlag), .errCount(errCount)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit expQ[$];
  bit hist[$];
  bit modeLong = 0;
  bit txRun = 0;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference sequence from the recurrence of R3
  function automatic bit modelNext();
    int k = hist.size();
    int n = modeLong ? 23 : 15;
    int tp = modeLong ? 18 : 14;
    bit b;
    if (k < n) b = 1'b1;
    else b = hist[k-n] ^ hist[k-tp];
    hist.push_back(b);
    return b;
  endfunction

  // driver: one strobe per cycle, expected tx bit pushed to the scoreboard
  task automatic runBits(input int n, input int flipPeriod);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      bitEn = 1'b1;
      flip = (flipPeriod > 0) && ((k % flipPeriod) == flipPeriod - 1);
      if (txRun) expQ.push_back(modelNext());
    end
    @(negedge clk);
    bitEn = 1'b0;
    flip = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops the scoreboard on every strobe (R3, R2 continuity, R11 reseed)
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (bitEn && expQ.size() > 0) begin
        bit e;
        e = expQ.pop_front();
        check("R3 tx sequence bit", int'(txBit), int'(e));
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 0; bitEn = 0; longMode = 0; genReset = 0; txStart = 0;
    rxStart = 0; errClear = 0; flip = 0;
    idle(5);
    rstN = 1;
    idle(1);
    check("R1 lock after reset", int'(lockFlag), 0);
    check("R1 count after reset", int'(errCount), 0);
    check("R1 tx bit after reset", int'(txBit), 0);

    // short mode: reseed, arm, start
    genReset = 1; idle(1); genReset = 0; hist.delete();
    rxStart = 1; idle(1);
    txStart = 1; txRun = 1; idle(1);
    runBits(14, 0);
    check("R5 no lock after 14 ones", int'(lockFlag), 0);
    runBits(1, 0);
    check("R5 lock on 15th one", int'(lockFlag), 1);
    runBits(100, 20);
    check("R6 five injected errors", int'(errCount), 5);

    // R10: flipped bits without strobe
    flip = 1; idle(5); flip = 0; idle(1);
    check("R10 no strobe no count", int'(errCount), 5);

    // R7: receiver off
    rxStart = 0; idle(1);
    runBits(40, 4);
    check("R7 count frozen", int'(errCount), 5);
    check("R7 lock holds", int'(lockFlag), 1);

    // R8 clear, then held high (R11)
    errClear = 1; idle(1);
    check("R8 clear zeroes count", int'(errCount), 0);
    rxStart = 1; idle(1);
    check("R5 arm clears lock", int'(lockFlag), 0);
    genReset = 1; hist.delete(); idle(1);
    runBits(15, 0);
    check("R4 reseed gives lock", int'(lockFlag), 1);
    runBits(60, 6);
    check("R11 held clear does not block counting", int'(errCount), 10);
    genReset = 0; errClear = 0; idle(1);

    // R2: stop and resume
    rxStart = 0; idle(1);
    txStart = 0; txRun = 0; idle(1);
    runBits(1, 0);
    check("R2 tx bit low when stopped", int'(txBit), 0);
    runBits(9, 0);
    txStart = 1; txRun = 1; idle(1);
    runBits(30, 0);
    check("R2 resumed without count change", int'(errCount), 10);

    // long mode
    longMode = 1; modeLong = 1;
    genReset = 1; hist.delete(); idle(1); genReset = 0;
    errClear = 1; idle(1); errClear = 0;
    rxStart = 1; idle(1);
    check("R5 lock cleared before long search", int'(lockFlag), 0);
    runBits(22, 0);
    check("R5 no lock after 22 ones", int'(lockFlag), 0);
    runBits(1, 0);
    check("R5 lock on 23rd one", int'(lockFlag), 1);
    runBits(200, 25);
    check("R6 long mode errors", int'(errCount), 8);

    // R8 clear wins over an error on the same strobe
    @(negedge clk);
    bitEn = 1; flip = 1; errClear = 1;
    expQ.push_back(modelNext());
    @(negedge clk);
    bitEn = 0; flip = 0;
    check("R8 clear beats error", int'(errCount), 0);
    errClear = 0; idle(1);

    // R9 saturation
    runBits(65600, 1);
    check("R9 count saturates", int'(errCount), 65535);
    runBits(10, 1);
    check("R9 count stays saturated", int'(errCount), 65535);
    check("R6 lock kept through errors", int'(lockFlag), 1);

    idle(2);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule